// File: doc/BRIEF.md
# Manchester Bit-Half Evaluator with Collision Detection

This block sits behind a receive correlator. For each Manchester-coded bit it takes one signal-strength value for the first half of the bit and one for the second half. It then sorts the bit into one of three classes: a valid bit with a known value, a collision between two transmitters answering at once, or a bit too weak to trust. The correlator feeds two receive channels, I and Q. Each channel brings a strength value and a strobe for each bit half. A select input chooses which channel's timing and strengths drive the decision.

After the local transmitter finishes, a one-cycle transmit-done pulse starts a guard interval. During that interval the receiver stays deaf. The interval lasts a programmable number of bit periods, and each bit period is a programmable number of clock cycles. Evaluation starts only when the guard interval has run out.

The block has two state machines. The guard machine has three states. `G_OFF` holds the receiver deaf after reset. `G_WAIT` counts the guard interval. `G_LISTEN` allows evaluation. Its transitions are named *arm* (`G_OFF` or `G_LISTEN` to `G_WAIT` on transmit-done), *expire* (`G_WAIT` to `G_LISTEN` when the count runs out) and *re-arm* (`G_WAIT` to `G_WAIT` on a new transmit-done). The evaluation machine has two states. `EV_IDLE` waits for a first half. `EV_HALF` holds the captured first half and waits for the second. Its transitions are named *capture* (`EV_IDLE` to `EV_HALF`), *finish* (`EV_HALF` to `EV_IDLE` on a second half, which raises the bit strobe) and *abort* (`EV_HALF` to `EV_IDLE` when the receiver is disabled).

Top module: `mbe_bit_evaluator`

## Requirements
- R1: While reset is high and in the cycle after it, `rx_active`, `bit_stb`, `bit_valid`, `bit_coll` and `bit_val` are all 0.
- R2: After a transmit-done pulse is sampled, `rx_active` rises exactly `guard_bits * bit_cycles` clock cycles later when `guard_bits` ≥ 1. When `guard_bits` is 0 it rises one cycle later. A `bit_cycles` value of 0 is treated as 1.
- R3: While `rx_active` is low, bit-half strobes produce no `bit_stb`.
- R4: `bit_stb` is high for exactly one cycle: the cycle after the edge on which the second-half strobe is sampled, following an earlier first-half strobe.
- R5: If the stronger half's strength is below `min_level`, the bit is still strobed, with `bit_valid` = 0 and `bit_coll` = 0. A stronger half equal to `min_level` counts as strong enough.
- R6: If `min_level` is met and weaker×16 > stronger×`coll_level` (unsigned integer arithmetic), the bit is strobed with `bit_coll` = 1 and `bit_valid` = 0. Equality is not a collision.
- R7: Otherwise the bit is strobed with `bit_valid` = 1, `bit_coll` = 0 and `bit_val` = 1 when the first half is at least as strong as the second, or 0 when the second half is stronger.
- R8: `chan_sel` = 1 evaluates the I-channel inputs. `chan_sel` = 0 evaluates the Q-channel inputs. Strobes on the unselected channel produce no `bit_stb`.
- R9: A transmit-done pulse while listening drops `rx_active` on the next cycle and restarts the full guard interval.
- R10: A second-half strobe with no pending first half produces no `bit_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| i_h1_str | input | SW | I-channel first-half strength |
| i_h2_str | input | SW | I-channel second-half strength |
| i_h1_stb | input | 1 | I-channel first-half strobe |
| i_h2_stb | input | 1 | I-channel second-half strobe |
| q_h1_str | input | SW | Q-channel first-half strength |
| q_h2_str | input | SW | Q-channel second-half strength |
| q_h1_stb | input | 1 | Q-channel first-half strobe |
| q_h2_stb | input | 1 | Q-channel second-half strobe |
| chan_sel | input | 1 | 1 selects the I channel, 0 selects the Q channel |
| min_level | input | 4 | Minimum strength the stronger half must reach |
| coll_level | input | 4 | Collision ratio, in sixteenths of the stronger half |
| guard_bits | input | GW | Guard interval in bit periods |
| bit_cycles | input | CW | Clock cycles per bit period |
| tx_done | input | 1 | One-cycle pulse marking the end of a transmission |
| rx_active | output | 1 | Receiver enabled (guard interval over) |
| bit_stb | output | 1 | One-cycle strobe for an evaluated bit |
| bit_val | output | 1 | Decoded bit value |
| bit_valid | output | 1 | Bit is valid |
| bit_coll | output | 1 | Bit is a collision |

## Verification
A guard machine stuck in the wrong state shows up at `rx_active`. It moves the rising edge off the computed guard cycle, or lets that edge appear after a fresh transmit-done, and either fault is visible within one bit period of the expected edge. A wrong evaluation state shows up on the very next bit. A pending first half that is lost drops the strobe. A stray one makes an orphan second half raise the strobe. A wrong captured strength flips `bit_val`, or flips the class between valid, collision and weak, on the strobe cycle itself.

// File: rtl/mbe_pkg.sv
package mbe_pkg;
    typedef enum logic [1:0] {G_OFF, G_WAIT, G_LISTEN} guard_state_t;
    typedef enum logic {EV_IDLE, EV_HALF} eval_state_t;
endpackage

// File: rtl/mbe_chan_mux.sv
module mbe_chan_mux #(
    parameter int SW = 4
) (
    input  logic          chan_sel,
    input  logic [SW-1:0] i_h1_str,
    input  logic [SW-1:0] i_h2_str,
    input  logic          i_h1_stb,
    input  logic          i_h2_stb,
    input  logic [SW-1:0] q_h1_str,
    input  logic [SW-1:0] q_h2_str,
    input  logic          q_h1_stb,
    input  logic          q_h2_stb,
    output logic [SW-1:0] h1_str,
    output logic [SW-1:0] h2_str,
    output logic          h1_stb,
    output logic          h2_stb
);
    always_comb begin
        if (chan_sel) begin
            h1_str = i_h1_str;
            h2_str = i_h2_str;
            h1_stb = i_h1_stb;
            h2_stb = i_h2_stb;
        end else begin
            h1_str = q_h1_str;
            h2_str = q_h2_str;
            h1_stb = q_h1_stb;
            h2_stb = q_h2_stb;
        end
    end
endmodule

// File: rtl/mbe_guard_timer.sv
module mbe_guard_timer
    import mbe_pkg::*;
#(
    parameter int GW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_done,
    input  logic [GW-1:0] guard_bits,
    input  logic [CW-1:0] bit_cycles,
    output logic          rx_active
);
    guard_state_t  state, state_nx;
    logic [GW-1:0] gcnt;
    logic [CW-1:0] ccnt;
    logic [CW-1:0] bit_len;
    logic          tick;

    assign bit_len   = (bit_cycles == '0) ? CW'(1) : bit_cycles;
    assign tick      = (state == G_WAIT) && (ccnt == bit_len - CW'(1));
    assign rx_active = (state == G_LISTEN);

    always_comb begin
        state_nx = state;
        unique case (state)
            G_OFF:    if (tx_done) state_nx = G_WAIT;
            G_WAIT: begin
                if (tx_done)                          state_nx = G_WAIT;
                else if (gcnt == '0)                  state_nx = G_LISTEN;
                else if (tick && gcnt == GW'(1))      state_nx = G_LISTEN;
            end
            G_LISTEN: if (tx_done) state_nx = G_WAIT;
            default:  state_nx = G_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= G_OFF;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gcnt <= '0;
            ccnt <= '0;
        end else if (tx_done) begin
            gcnt <= guard_bits;
            ccnt <= '0;
        end else if (state == G_WAIT) begin
            if (tick) begin
                ccnt <= '0;
                if (gcnt != '0) gcnt <= gcnt - GW'(1);
            end else begin
                ccnt <= ccnt + CW'(1);
            end
        end
    end

    // R9
    tx_done_deafens_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> !rx_active);

    // R2
    listen_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_active) |-> $past(state == G_WAIT));

    // R2
    guard_count_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        (state == G_WAIT && $past(state == G_WAIT) && !$past(tx_done))
            |-> gcnt <= $past(gcnt));

    // R1
    reset_deaf_chk: assert property (@(posedge clk)
        rst |=> !rx_active);
endmodule

// File: rtl/mbe_classifier.sv
module mbe_classifier #(
    parameter int SW = 4
) (
    input  logic [SW-1:0] first_str,
    input  logic [SW-1:0] second_str,
    input  logic [3:0]    min_level,
    input  logic [3:0]    coll_level,
    output logic          min_ok,
    output logic          coll_hit,
    output logic          value
);
    localparam int CMPW = (SW > 4) ? SW : 4;
    localparam int PW   = SW + 4;

    logic [SW-1:0]   stronger, weaker;
    logic [CMPW-1:0] strong_ext, min_ext;
    logic [PW-1:0]   weak_x16, strong_x_coll;

    always_comb begin
        value         = (first_str >= second_str);
        stronger      = value ? first_str  : second_str;
        weaker        = value ? second_str : first_str;
        strong_ext    = CMPW'(stronger);
        min_ext       = CMPW'(min_level);
        min_ok        = (strong_ext >= min_ext);
        weak_x16      = {weaker, 4'b0000};
        strong_x_coll = PW'(stronger) * PW'(coll_level);
        coll_hit      = (weak_x16 > strong_x_coll);
    end
endmodule

// File: rtl/mbe_bit_evaluator.sv
module mbe_bit_evaluator
    import mbe_pkg::*;
#(
    parameter int SW = 4,
    parameter int GW = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] i_h1_str,
    input  logic [SW-1:0] i_h2_str,
    input  logic          i_h1_stb,
    input  logic          i_h2_stb,
    input  logic [SW-1:0] q_h1_str,
    input  logic [SW-1:0] q_h2_str,
    input  logic          q_h1_stb,
    input  logic          q_h2_stb,
    input  logic          chan_sel,
    input  logic [3:0]    min_level,
    input  logic [3:0]    coll_level,
    input  logic [GW-1:0] guard_bits,
    input  logic [CW-1:0] bit_cycles,
    input  logic          tx_done,
    output logic          rx_active,
    output logic          bit_stb,
    output logic          bit_val,
    output logic          bit_valid,
    output logic          bit_coll
);
    eval_state_t   state, state_nx;
    logic [SW-1:0] sel_h1_str, sel_h2_str, first_q;
    logic          sel_h1_stb, sel_h2_stb;
    logic          min_ok, coll_hit, value;
    logic          finish;

    mbe_chan_mux #(.SW(SW)) mux_i (
        .chan_sel (chan_sel),
        .i_h1_str (i_h1_str), .i_h2_str (i_h2_str),
        .i_h1_stb (i_h1_stb), .i_h2_stb (i_h2_stb),
        .q_h1_str (q_h1_str), .q_h2_str (q_h2_str),
        .q_h1_stb (q_h1_stb), .q_h2_stb (q_h2_stb),
        .h1_str   (sel_h1_str), .h2_str (sel_h2_str),
        .h1_stb   (sel_h1_stb), .h2_stb (sel_h2_stb)
    );

    mbe_guard_timer #(.GW(GW), .CW(CW)) guard_i (
        .clk        (clk),
        .rst        (rst),
        .tx_done    (tx_done),
        .guard_bits (guard_bits),
        .bit_cycles (bit_cycles),
        .rx_active  (rx_active)
    );

    mbe_classifier #(.SW(SW)) cls_i (
        .first_str  (first_q),
        .second_str (sel_h2_str),
        .min_level  (min_level),
        .coll_level (coll_level),
        .min_ok     (min_ok),
        .coll_hit   (coll_hit),
        .value      (value)
    );

    assign finish = (state == EV_HALF) && rx_active && sel_h2_stb;

    always_comb begin
        state_nx = state;
        unique case (state)
            EV_IDLE: if (rx_active && sel_h1_stb) state_nx = EV_HALF;
            EV_HALF: begin
                if (!rx_active)      state_nx = EV_IDLE;
                else if (sel_h2_stb) state_nx = EV_IDLE;
            end
            default: state_nx = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= EV_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
        end else if (rx_active && sel_h1_stb && !finish) begin
            first_q <= sel_h1_str;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_stb   <= 1'b0;
            bit_val   <= 1'b0;
            bit_valid <= 1'b0;
            bit_coll  <= 1'b0;
        end else begin
            bit_stb <= finish;
            if (finish) begin
                bit_valid <= min_ok && !coll_hit;
                bit_coll  <= min_ok && coll_hit;
                bit_val   <= min_ok && !coll_hit && value;
            end
        end
    end

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |=> !bit_stb);

    // R3
    strobe_needs_rx_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> $past(rx_active));

    // R6
    class_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && bit_coll));

    // R10
    strobe_needs_half_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb |-> $past(state == EV_HALF));
endmodule

// File: tb/mbe_bit_evaluator_tb.sv
module mbe_bit_evaluator_tb_top;
    localparam int SW = 4;
    localparam int GW = 8;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] i_h1_str = '0, i_h2_str = '0, q_h1_str = '0, q_h2_str = '0;
    logic          i_h1_stb = 1'b0, i_h2_stb = 1'b0, q_h1_stb = 1'b0, q_h2_stb = 1'b0;
    logic          chan_sel = 1'b1;
    logic [3:0]    min_level = 4'd0, coll_level = 4'd8;
    logic [GW-1:0] guard_bits = '0;
    logic [CW-1:0] bit_cycles = CW'(4);
    logic          tx_done = 1'b0;
    logic          rx_active, bit_stb, bit_val, bit_valid, bit_coll;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbe_bit_evaluator #(.SW(SW), .GW(GW), .CW(CW)) dut_i (
        .clk (clk), .rst (rst),
        .i_h1_str (i_h1_str), .i_h2_str (i_h2_str),
        .i_h1_stb (i_h1_stb), .i_h2_stb (i_h2_stb),
        .q_h1_str (q_h1_str), .q_h2_str (q_h2_str),
        .q_h1_stb (q_h1_stb), .q_h2_stb (q_h2_stb),
        .chan_sel (chan_sel), .min_level (min_level), .coll_level (coll_level),
        .guard_bits (guard_bits), .bit_cycles (bit_cycles), .tx_done (tx_done),
        .rx_active (rx_active), .bit_stb (bit_stb), .bit_val (bit_val),
        .bit_valid (bit_valid), .bit_coll (bit_coll)
    );

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Pulse tx_done and return the number of cycles until rx_active rises.
    task automatic guard_run(input int g, input int n, output int cycles);
        guard_bits = GW'(g);
        bit_cycles = CW'(n);
        @(negedge clk) tx_done = 1'b1;
        @(posedge clk);
        @(negedge clk) tx_done = 1'b0;
        cycles = -1;
        for (int i = 1; i < 3000; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (rx_active) begin
                cycles = i;
                break;
            end
        end
    endtask

    // Drive a first half then a second half on one channel; report the result.
    task automatic drive_bit(input bit on_i, input logic [SW-1:0] a, input logic [SW-1:0] b,
                             input bit send_h1,
                             output bit seen, output bit val, output bit vld, output bit col,
                             output bit extra);
        @(negedge clk);
        if (send_h1) begin
            if (on_i) begin i_h1_str = a; i_h1_stb = 1'b1; end
            else      begin q_h1_str = a; q_h1_stb = 1'b1; end
        end
        @(negedge clk);
        i_h1_stb = 1'b0; q_h1_stb = 1'b0;
        if (on_i) begin i_h2_str = b; i_h2_stb = 1'b1; end
        else      begin q_h2_str = b; q_h2_stb = 1'b1; end
        @(negedge clk);
        i_h2_stb = 1'b0; q_h2_stb = 1'b0;
        seen = bit_stb; val = bit_val; vld = bit_valid; col = bit_coll;
        @(negedge clk);
        extra = bit_stb;
    endtask

    task automatic expect_class(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                output bit e_val, output bit e_vld, output bit e_col);
        int s, w;
        bit first_wins;
        first_wins = (a >= b);
        s = first_wins ? int'(a) : int'(b);
        w = first_wins ? int'(b) : int'(a);
        if (s < int'(min_level)) begin
            e_val = 0; e_vld = 0; e_col = 0;
        end else if (w * 16 > s * int'(coll_level)) begin
            e_val = 0; e_vld = 0; e_col = 1;
        end else begin
            e_val = first_wins; e_vld = 1; e_col = 0;
        end
    endtask

    task automatic classify_case(input string req, input logic [SW-1:0] a, input logic [SW-1:0] b);
        bit seen, val, vld, col, extra, ev, evl, ec;
        expect_class(a, b, ev, evl, ec);
        drive_bit(chan_sel, a, b, 1'b1, seen, val, vld, col, extra);
        check(seen, {req, " strobe"}, seen, 1);
        check(!extra, "R4 strobe width", extra, 0);
        check(vld == evl, {req, " valid"}, vld, evl);
        check(col == ec, {req, " collision"}, col, ec);
        check(val == ev, {req, " value"}, val, ev);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!rx_active, "R1 rx_active", rx_active, 0);
        check(!bit_stb, "R1 bit_stb", bit_stb, 0);
        check(!bit_valid && !bit_coll && !bit_val, "R1 flags", {bit_valid, bit_coll, bit_val}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rx_active && !bit_stb, "R1 after release", {rx_active, bit_stb}, 0);
    endtask

    task automatic t_deaf();
        bit seen, val, vld, col, extra;
        drive_bit(1'b1, 4'd12, 4'd1, 1'b1, seen, val, vld, col, extra);
        check(!seen && !extra, "R3 halves ignored while off", seen, 0);
    endtask

    task automatic t_guard();
        int c;
        guard_run(3, 4, c);
        check(c == 12, "R2 guard 3x4", c, 12);
        guard_run(0, 4, c);
        check(c == 1, "R2 guard zero", c, 1);
        guard_run(2, 0, c);
        check(c == 2, "R2 bit_cycles zero", c, 2);
        guard_run(1, 5, c);
        check(c == 5, "R2 guard 1x5", c, 5);
    endtask

    task automatic t_classes();
        chan_sel = 1'b1;
        min_level = 4'd5; coll_level = 4'd8;
        classify_case("R7 first stronger", 4'd12, 4'd3);
        classify_case("R7 second stronger", 4'd2, 4'd13);
        classify_case("R5 below min", 4'd4, 4'd1);
        classify_case("R5 at min", 4'd5, 4'd0);
        classify_case("R6 collision", 4'd10, 4'd9);
        classify_case("R6 equality no collision", 4'd8, 4'd4);
        classify_case("R6 just over", 4'd8, 4'd5);
        coll_level = 4'd0;
        classify_case("R6 zero ratio", 4'd9, 4'd1);
        coll_level = 4'd15; min_level = 4'd0;
        classify_case("R7 both zero", 4'd0, 4'd0);
    endtask

    task automatic t_channel();
        bit seen, val, vld, col, extra;
        min_level = 4'd2; coll_level = 4'd8;
        chan_sel = 1'b1;
        drive_bit(1'b0, 4'd12, 4'd1, 1'b1, seen, val, vld, col, extra);
        check(!seen && !extra, "R8 Q ignored when I selected", seen, 0);
        chan_sel = 1'b0;
        drive_bit(1'b1, 4'd12, 4'd1, 1'b1, seen, val, vld, col, extra);
        check(!seen && !extra, "R8 I ignored when Q selected", seen, 0);
        classify_case("R8 Q selected", 4'd1, 4'd14);
        chan_sel = 1'b1;
        classify_case("R8 I selected", 4'd14, 4'd1);
    endtask

    task automatic t_orphan();
        bit seen, val, vld, col, extra;
        drive_bit(1'b1, 4'd0, 4'd12, 1'b0, seen, val, vld, col, extra);
        check(!seen && !extra, "R10 orphan second half", seen, 0);
    endtask

    task automatic t_rearm();
        bit seen, val, vld, col, extra;
        int c;
        guard_bits = GW'(4); bit_cycles = CW'(3);
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        check(!rx_active, "R9 deaf after pulse", rx_active, 0);
        drive_bit(1'b1, 4'd12, 4'd1, 1'b1, seen, val, vld, col, extra);
        check(!seen && !extra, "R9 bit ignored during guard", seen, 0);
        guard_run(4, 3, c);
        check(c == 12, "R9 full guard restart", c, 12);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_deaf();
        t_guard();
        t_classes();
        t_channel();
        t_orphan();
        t_rearm();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog got=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule